// File: doc/BRIEF.md
# Serial Register Write Port

This block is a write-only target on a two-wire serial bus with START/STOP framing. It samples the bus clock and data lines on a fast system clock. It recognises START, repeated START and STOP, and compares the first byte of each transfer against its own 7-bit bus address with a write direction bit. After that it takes one byte as a register pointer, and every further byte is stored at the pointer, which then steps forward by one. The target answers each byte it accepts by pulling the data line low for the acknowledge bit.

The store holds nine bytes: a control byte, an LED byte, three alarm time bytes (hours first), three watch time bytes (hours first) and an impedance byte. All nine bytes are always visible as parallel outputs. Time fields are narrowed as they are written, and the watch hour is limited to a legal hour. Each stored byte raises a one-cycle strobe, so neighbouring logic can react to a fresh value.

Top module: `i2c_regwr_slave`

## Requirements
- R1: A transfer that opens with a byte equal to the bus address followed by a direction bit of 0 is acknowledged. The next byte is acknowledged and loaded as the register pointer. Each later byte is acknowledged and stored at the pointer.
- R2: An acknowledge holds `sdaOe` high from the falling SCL edge after the eighth data bit to the falling edge after the ninth bit, so the line reads low while SCL is high in the ninth bit.
- R3: After each stored byte the pointer steps by one, so a burst fills consecutive registers. The store raises exactly one bit of `wrStrobe`, the bit whose index equals the register index, for one cycle.
- R4: If the first byte differs from the bus address, or carries a direction bit of 1, that byte is not acknowledged. No later byte before the next START is acknowledged, and none changes any register.
- R5: After reset the register outputs are: control 0, LED 0, alarm hours 31, alarm minutes 63, alarm seconds 63, all watch fields 0, impedance 0.
- R6: Indices 0 control, 1 LED and 8 impedance keep all 8 bits. Index 2 alarm hours keeps bits 4:0. Indices 3, 4, 6 and 7 (minutes and seconds) keep bits 5:0. Upper bits read 0; for example 70 stores 6 and 81 stores 17.
- R7: Index 5 watch hours keeps bits 4:0, and a result above 23 is stored as 23.
- R8: A data byte that arrives while the pointer is 9 or more is acknowledged but changes no register and raises no strobe. This covers a pointer byte above 8 and a burst that runs past index 8.
- R9: A repeated START without STOP begins a new address match. The earlier outcome, whether matched or mismatched, does not carry over.
- R10: After a STOP, and whenever no transfer is open, `sdaOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaOe | output | 1 | High pulls the data line low (acknowledge) |
| ctrlReg | output | 8 | Index 0, control byte |
| ledReg | output | 8 | Index 1, LED byte |
| alarmHours | output | 8 | Index 2, alarm hours |
| alarmMins | output | 8 | Index 3, alarm minutes |
| alarmSecs | output | 8 | Index 4, alarm seconds |
| watchHours | output | 8 | Index 5, watch hours |
| watchMins | output | 8 | Index 6, watch minutes |
| watchSecs | output | 8 | Index 7, watch seconds |
| impReg | output | 8 | Index 8, impedance byte |
| wrStrobe | output | 9 | One-cycle store pulse, bit k for index k |

## Verification
The bench targets five kinds of fault. A pointer that wraps or keeps counting past the last register would overwrite index 0 or 1 when a burst runs off the end. A mismatched or read-direction select that is not latched would let later bytes be acknowledged and stored. A repeated START that fails to reset the match state would carry a rejection into the next transfer, or an acceptance into it. The field narrowing would show as 70 read back instead of 6, or 25 instead of 23 in the watch hour. Randomised bursts with mixed pointers, lengths and select bytes are compared against a bench model of the store and against a count of expected strobes.

// File: rtl/regwr_pkg.sv
package regwr_pkg;

  localparam int REG_COUNT = 9;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = 4;
  localparam int HOUR_W    = 5;
  localparam int MINSEC_W  = 6;
  localparam int HOUR_MAX  = 23;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_POINTER,
    ST_DATA,
    ST_SKIP
  } ctlState_t;

  typedef struct packed {
    logic              loadPtr;
    logic              writeByte;
    logic [BYTE_W-1:0] rxByte;
  } dpStrobe_t;

  function automatic logic [BYTE_W-1:0] resetValue(input int unsigned idx);
    case (idx)
      2:       resetValue = BYTE_W'((1 << HOUR_W) - 1);
      3, 4:    resetValue = BYTE_W'((1 << MINSEC_W) - 1);
      default: resetValue = '0;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] fieldFilter(input int unsigned idx,
                                                     input logic [BYTE_W-1:0] v);
    logic [HOUR_W-1:0] hr;
    hr = v[HOUR_W-1:0];
    case (idx)
      2:             fieldFilter = BYTE_W'(hr);
      5:             fieldFilter = (hr > HOUR_W'(HOUR_MAX)) ? BYTE_W'(HOUR_MAX) : BYTE_W'(hr);
      3, 4, 6, 7:    fieldFilter = BYTE_W'(v[MINSEC_W-1:0]);
      default:       fieldFilter = v;
    endcase
  endfunction

endpackage

// File: rtl/i2c_ctl.sv
module i2c_ctl
  import regwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      scl,
  input  logic      sdaIn,
  output logic      sdaOe,
  output dpStrobe_t strb,
  output logic      busIdle,
  output logic      skipping
);

  localparam logic [BIT_CNT_W-1:0] LAST_DATA_BIT = BIT_CNT_W'(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] ACK_PHASE     = BIT_CNT_W'(BYTE_W + 1);
  localparam logic [BYTE_W-1:0]    MATCH_BYTE    = {DEV_ADDR, 1'b0};

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startDet, stopDet;

  ctlState_t              state;
  logic [BIT_CNT_W-1:0]   bitCnt;
  logic [BYTE_W-1:0]      shiftReg;
  logic                   ackOn;

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], scl};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      ackOn    <= 1'b0;
      strb     <= '0;
    end else begin
      strb <= '0;
      if (startDet) begin
        state  <= ST_DEVSEL;
        bitCnt <= '0;
        ackOn  <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        ackOn  <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise && bitCnt < LAST_DATA_BIT) begin
          shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
          bitCnt   <= bitCnt + 1'b1;
        end else if (sclFall && bitCnt == LAST_DATA_BIT) begin
          bitCnt <= ACK_PHASE;
          case (state)
            ST_DEVSEL:  ackOn <= (shiftReg == MATCH_BYTE);
            ST_POINTER: begin
              ackOn        <= 1'b1;
              strb.loadPtr <= 1'b1;
              strb.rxByte  <= shiftReg;
            end
            ST_DATA: begin
              ackOn          <= 1'b1;
              strb.writeByte <= 1'b1;
              strb.rxByte    <= shiftReg;
            end
            default: ackOn <= 1'b0;
          endcase
        end else if (sclFall && bitCnt == ACK_PHASE) begin
          bitCnt <= '0;
          ackOn  <= 1'b0;
          case (state)
            ST_DEVSEL:  state <= ackOn ? ST_POINTER : ST_SKIP;
            ST_POINTER: state <= ST_DATA;
            default:    state <= state;
          endcase
        end
      end
    end
  end

  assign sdaOe    = ackOn;
  assign busIdle  = (state == ST_IDLE);
  assign skipping = (state == ST_SKIP);

endmodule

// File: rtl/regmap_dp.sv
module regmap_dp
  import regwr_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  dpStrobe_t                          strb,
  output logic [REG_COUNT-1:0][BYTE_W-1:0]   regOut,
  output logic [REG_COUNT-1:0]               wrStrobe
);

  localparam logic [BYTE_W-1:0] PTR_END = BYTE_W'(REG_COUNT);

  logic [BYTE_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.loadPtr) begin
      ptr <= strb.rxByte;
    end else if (strb.writeByte && ptr < PTR_END) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic hit;
    assign hit = strb.writeByte && (ptr == BYTE_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regOut[g]   <= resetValue(g);
        wrStrobe[g] <= 1'b0;
      end else begin
        wrStrobe[g] <= hit;
        if (hit) regOut[g] <= fieldFilter(g, strb.rxByte);
      end
    end
  end

endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
  import regwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  scl,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [7:0]            ctrlReg,
  output logic [7:0]            ledReg,
  output logic [7:0]            alarmHours,
  output logic [7:0]            alarmMins,
  output logic [7:0]            alarmSecs,
  output logic [7:0]            watchHours,
  output logic [7:0]            watchMins,
  output logic [7:0]            watchSecs,
  output logic [7:0]            impReg,
  output logic [REG_COUNT-1:0]  wrStrobe
);

  dpStrobe_t                           strb;
  logic                                busIdle, skipping;
  logic [REG_COUNT-1:0][BYTE_W-1:0]    regFlat;

  i2c_ctl #(.DEV_ADDR(DEV_ADDR)) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .scl      (scl),
    .sdaIn    (sdaIn),
    .sdaOe    (sdaOe),
    .strb     (strb),
    .busIdle  (busIdle),
    .skipping (skipping)
  );

  regmap_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regOut   (regFlat),
    .wrStrobe (wrStrobe)
  );

  assign ctrlReg    = regFlat[0];
  assign ledReg     = regFlat[1];
  assign alarmHours = regFlat[2];
  assign alarmMins  = regFlat[3];
  assign alarmSecs  = regFlat[4];
  assign watchHours = regFlat[5];
  assign watchMins  = regFlat[6];
  assign watchSecs  = regFlat[7];
  assign impReg     = regFlat[8];

endmodule

// File: rtl/i2c_regwr_chk.sv
module i2c_regwr_chk
  import regwr_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic                              sdaOe,
  input logic [REG_COUNT-1:0]              wrStrobe,
  input logic [7:0]                        watchHours,
  input logic                              busIdle,
  input logic                              skipping,
  input logic [REG_COUNT-1:0][BYTE_W-1:0]  regView
);

  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStrobe));

  p_store_acked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|wrStrobe) |-> sdaOe);

  p_no_silent_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regView) |-> (|wrStrobe));

  p_watch_hour_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
    watchHours <= 8'd23);

  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> !sdaOe);

  p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    skipping |-> (!sdaOe && wrStrobe == '0));

endmodule

bind i2c_regwr_slave i2c_regwr_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sdaOe      (sdaOe),
  .wrStrobe   (wrStrobe),
  .watchHours (watchHours),
  .busIdle    (busIdle),
  .skipping   (skipping),
  .regView    (regFlat)
);

// File: tb/i2c_regwr_slave_tb_top.sv
module i2c_regwr_slave_tb_top;

  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic busSda;
  logic sdaOe;
  logic [7:0] ctrlReg, ledReg, alarmHours, alarmMins, alarmSecs;
  logic [7:0] watchHours, watchMins, watchSecs, impReg;
  logic [8:0] wrStrobe;

  assign busSda = sdaM & ~sdaOe;

  i2c_regwr_slave #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rstN(rstN), .scl(sclM), .sdaIn(busSda), .sdaOe(sdaOe),
    .ctrlReg(ctrlReg), .ledReg(ledReg), .alarmHours(alarmHours),
    .alarmMins(alarmMins), .alarmSecs(alarmSecs), .watchHours(watchHours),
    .watchMins(watchMins), .watchSecs(watchSecs), .impReg(impReg),
    .wrStrobe(wrStrobe)
  );

  int errs = 0;
  int checks = 0;
  int strobeSeen = 0;
  int strobeExp = 0;
  int ptrModel = 0;
  bit done = 1'b0;
  logic [7:0] model [9];
  logic [7:0] burst [8];

  always @(posedge clk) if (rstN) strobeSeen += $countones(wrStrobe);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Expected stored value per register index, from R6/R7
  function automatic logic [7:0] expStore(input int idx, input logic [7:0] v);
    int h;
    if (idx == 2) return v & 8'h1F;
    if (idx == 5) begin
      h = int'(v & 8'h1F);
      return (h > 23) ? 8'd23 : 8'(h);
    end
    if (idx == 3 || idx == 4 || idx == 6 || idx == 7) return v & 8'h3F;
    return v;
  endfunction

  function automatic logic [7:0] dutReg(input int i);
    case (i)
      0: return ctrlReg;
      1: return ledReg;
      2: return alarmHours;
      3: return alarmMins;
      4: return alarmSecs;
      5: return watchHours;
      6: return watchMins;
      7: return watchSecs;
      default: return impReg;
    endcase
  endfunction

  task automatic busStart();
    sdaM = 1'b1; waitc(8);
    sclM = 1'b1; waitc(16);
    sdaM = 1'b0; waitc(16);
    sclM = 1'b0; waitc(8);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitc(8);
    sclM = 1'b1; waitc(16);
    sdaM = 1'b1; waitc(16);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitc(8);
      sclM = 1'b1; waitc(16);
      sclM = 1'b0; waitc(8);
    end
    sdaM = 1'b1; waitc(8);
    sclM = 1'b1; waitc(8);
    ack = !busSda;
    waitc(8);
    sclM = 1'b0; waitc(8);
  endtask

  // Select byte, pointer byte and n data bytes; no START/STOP here.
  task automatic body(input logic [7:0] sel, input logic [7:0] ptrByte, input int n);
    bit ack;
    bit good;
    good = (sel == {DEV, 1'b0});
    sendByte(sel, ack);
    if (good) chk(ack == 1'b1, "R1/R2 select ack", int'(ack), 1);
    else      chk(ack == 1'b0, "R4 select nack", int'(ack), 0);
    sendByte(ptrByte, ack);
    chk(ack == good, good ? "R1 pointer ack" : "R4 pointer nack", int'(ack), int'(good));
    if (good) ptrModel = int'(ptrByte);
    for (int k = 0; k < n; k++) begin
      sendByte(burst[k], ack);
      chk(ack == good, good ? "R3/R8 data ack" : "R4 data nack", int'(ack), int'(good));
      if (good && ptrModel < 9) begin
        model[ptrModel] = expStore(ptrModel, burst[k]);
        strobeExp++;
        ptrModel++;
      end
    end
  endtask

  task automatic checkAll(input string tag);
    for (int i = 0; i < 9; i++)
      chk(dutReg(i) == model[i], tag, int'(dutReg(i)), int'(model[i]));
    chk(strobeSeen == strobeExp, "R3 strobe count", strobeSeen, strobeExp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] sel;
    for (int i = 0; i < 9; i++) model[i] = 8'd0;
    model[2] = 8'd31; model[3] = 8'd63; model[4] = 8'd63;
    waitc(10);
    rstN = 1'b1;
    waitc(10);

    // R5 reset values
    checkAll("R5 reset value");
    chk(sdaOe == 1'b0, "R10 idle release", int'(sdaOe), 0);

    // R6 truncation of alarm fields, alarm hour not clamped
    burst[0] = 8'd25; burst[1] = 8'd70; burst[2] = 8'd81;
    busStart(); body({DEV, 1'b0}, 8'd2, 3); busStop();
    checkAll("R6 alarm narrowing");
    chk(alarmMins == 8'd6, "R6 70 to 6", int'(alarmMins), 6);
    chk(sdaOe == 1'b0, "R10 after stop", int'(sdaOe), 0);

    // R7 watch hour clamp, run into impedance then past end (R8)
    burst[0] = 8'd25; burst[1] = 8'd70; burst[2] = 8'd81;
    burst[3] = 8'hA5; burst[4] = 8'h3C; burst[5] = 8'hFF;
    busStart(); body({DEV, 1'b0}, 8'd5, 6); busStop();
    checkAll("R7/R8 clamp and overrun");
    chk(watchHours == 8'd23, "R7 25 clamps to 23", int'(watchHours), 23);
    chk(ctrlReg == 8'd0, "R8 no wrap to index 0", int'(ctrlReg), 0);

    // R8 pointer beyond the map
    burst[0] = 8'h77; burst[1] = 8'h66;
    busStart(); body({DEV, 1'b0}, 8'd200, 2); busStop();
    checkAll("R8 pointer out of range");

    // R4 wrong address and read direction
    burst[0] = 8'h12; burst[1] = 8'h34;
    busStart(); body({7'h13, 1'b0}, 8'd0, 2); busStop();
    checkAll("R4 wrong address ignored");
    busStart(); body({DEV, 1'b1}, 8'd1, 2); busStop();
    checkAll("R4 read direction ignored");

    // R9 repeated START: good -> bad -> good, no STOP between
    burst[0] = 8'h11;
    busStart(); body({DEV, 1'b0}, 8'd1, 1);
    busStart(); body({7'h55, 1'b0}, 8'd0, 1);
    burst[0] = 8'h5A;
    busStart(); body({DEV, 1'b0}, 8'd8, 1);
    busStop();
    checkAll("R9 repeated start");
    chk(impReg == 8'h5A, "R9 match after reject", int'(impReg), 8'h5A);

    // Randomised transfers (R1 R3 R4 R6 R7 R8)
    void'($urandom(32'd20240611));
    for (int t = 0; t < 24; t++) begin
      int n;
      int pick;
      n = 1 + int'($urandom % 5);
      for (int k = 0; k < n; k++) burst[k] = 8'($urandom);
      pick = int'($urandom % 10);
      if (pick == 0)      sel = {7'h2B, 1'b0};
      else if (pick == 1) sel = {DEV, 1'b1};
      else                sel = {DEV, 1'b0};
      busStart();
      body(sel, 8'($urandom % 11), n);
      busStop();
      checkAll("R1/R3 random burst");
    end
    chk(sdaOe == 1'b0, "R10 final idle", int'(sdaOe), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule